// File: doc/BRIEF.md
# Aligned transfer command segmenter

This block turns a request to move a run of bytes in a remote memory space into a list of sub-transfers. Every sub-transfer starts at an address that is naturally aligned for its kind, and the list is kept short. A request gives a start address, a byte count and a direction. The block then presents one descriptor at a time on a valid/ready output: a command code, the segment address and the segment length. After the last descriptor is taken, it pulses a completion flag.

Three kinds of segment are used: a 2-byte transfer, a 4-byte transfer, and a burst whose length is a multiple of 8 bytes up to a capped maximum. The block does not move any data and does not drive the serial link. A link engine downstream takes each descriptor, runs the matching transaction and accepts the next one.

Top module: `xfer_segmenter`

## Requirements
- R1: After reset, `req_ready` is 1 and `seg_valid`, `seg_done` and `seg_err` are 0.
- R2: A 2-byte segment (`seg_len` = 2) is emitted when the current address modulo 8 is 2 or 6, or when exactly 2 bytes remain.
- R3: When R2 does not apply, a 4-byte segment is emitted if the address modulo 8 is 4 or at most 6 bytes remain.
- R4: When neither R2 nor R3 applies, a burst is emitted. Its length is the remaining count rounded down to a multiple of 8, limited to `BURST_MAX` (240 by default).
- R5: `seg_cmd` is 0 or 1 for a 2-byte segment, 2 or 3 for a 4-byte segment, and 4 or 5 for a burst. The lower code of each pair is used for reads and the higher for writes.
- R6: The first segment address equals the request address. Each later address is the previous address plus the previous length. The lengths add up to the total. For example, reading 260 bytes from 0x60030002 gives lengths 2, 4, 240, 8, 4, 2.
- R7: An odd start address, or an odd length on a read, raises `seg_err` for one cycle, on the edge after acceptance. No segment is emitted and the block stays ready.
- R8: A write with an odd length is segmented as if its length were one byte longer.
- R9: `seg_done` pulses for exactly one cycle on the edge after the last segment handshake, and `seg_valid` is 0 while it is high. A zero-length request gives `seg_done` with no segment.
- R10: While `seg_valid` is 1 and `seg_ready` is 0, `seg_valid`, `seg_cmd`, `seg_addr` and `seg_len` hold their values.
- R11: `req_ready` is 0 from acceptance until `seg_done`. A request offered in that window is ignored and never produces segments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 for write, 0 for read |
| seg_valid | output | 1 | Descriptor present |
| seg_ready | input | 1 | Downstream takes the descriptor |
| seg_cmd | output | 3 | Command code (R5) |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | clog2(BURST_MAX+1) | Segment length in bytes |
| seg_done | output | 1 | One-cycle pulse when the range is covered |
| seg_err | output | 1 | One-cycle pulse on a rejected request |

## Verification
The shape checks on each segment assume two things. The remaining count is always even, which the padding and rejection rules guarantee. `BURST_MAX` is a multiple of 8. The stimulus keeps every legal request under 64 KiB and starts every request only while `req_ready` is high. The one exception is the deliberate busy-time offer, which is dropped before the block becomes idle. Backpressure is applied by toggling `seg_ready` on alternate vectors, so the hold rule is exercised together with the segment rules.

// File: rtl/segm_pkg.sv
package segm_pkg;

  typedef enum logic [1:0] {
    KIND_HALF  = 2'd0,
    KIND_WORD  = 2'd1,
    KIND_BURST = 2'd2
  } seg_kind_e;

  function automatic logic [2:0] cmd_code(input seg_kind_e kind, input logic wr);
    return {kind, wr};
  endfunction

endpackage

// File: rtl/segm_req_check.sv
module segm_req_check #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int REM_W = LEN_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              wr,
  output logic              bad,
  output logic [REM_W-1:0]  total
);

  always_comb begin
    bad   = addr[0] | (len[0] & ~wr);
    total = REM_W'(len) + REM_W'(len[0] & wr);
  end

endmodule

// File: rtl/segm_pick.sv
module segm_pick
  import segm_pkg::*;
#(
  parameter int REM_W     = 17,
  parameter int BURST_MAX = 240,
  localparam int SEG_W    = $clog2(BURST_MAX + 1)
) (
  input  logic [2:0]       align,
  input  logic [REM_W-1:0] rem,
  output seg_kind_e        kind,
  output logic [SEG_W-1:0] len
);

  localparam logic [REM_W-1:0] CAP = REM_W'(BURST_MAX);

  logic [REM_W-1:0] floor8;

  always_comb begin
    floor8 = {rem[REM_W-1:3], 3'b000};
    if (align == 3'd2 || align == 3'd6 || rem == REM_W'(2)) begin
      kind = KIND_HALF;
      len  = SEG_W'(2);
    end else if (align == 3'd4 || rem <= REM_W'(6)) begin
      kind = KIND_WORD;
      len  = SEG_W'(4);
    end else begin
      kind = KIND_BURST;
      len  = (floor8 > CAP) ? SEG_W'(BURST_MAX) : SEG_W'(floor8);
    end
  end

endmodule

// File: rtl/xfer_segmenter.sv
module xfer_segmenter
  import segm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BURST_MAX = 240,
  localparam int REM_W    = LEN_W + 1,
  localparam int SEG_W    = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [2:0]        seg_cmd,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [SEG_W-1:0]  seg_len,
  output logic              seg_done,
  output logic              seg_err
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e            state;
  logic [ADDR_W-1:0] cur_addr;
  logic [REM_W-1:0]  rem;
  logic              wr_q;

  logic              req_bad;
  logic [REM_W-1:0]  req_total;
  seg_kind_e         pick_kind;
  logic [SEG_W-1:0]  pick_len;
  logic              advance;

  segm_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_check (
    .addr  (req_addr),
    .len   (req_len),
    .wr    (req_write),
    .bad   (req_bad),
    .total (req_total)
  );

  segm_pick #(.REM_W(REM_W), .BURST_MAX(BURST_MAX)) u_pick (
    .align (cur_addr[2:0]),
    .rem   (rem),
    .kind  (pick_kind),
    .len   (pick_len)
  );

  assign req_ready = (state == ST_IDLE);
  assign advance   = !seg_valid || seg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      rem       <= '0;
      wr_q      <= 1'b0;
      seg_valid <= 1'b0;
      seg_cmd   <= '0;
      seg_addr  <= '0;
      seg_len   <= '0;
      seg_done  <= 1'b0;
      seg_err   <= 1'b0;
    end else begin
      seg_done <= 1'b0;
      seg_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_bad) begin
              seg_err <= 1'b1;
            end else begin
              cur_addr <= req_addr;
              rem      <= req_total;
              wr_q     <= req_write;
              state    <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (advance) begin
            if (rem != '0) begin
              seg_valid <= 1'b1;
              seg_cmd   <= cmd_code(pick_kind, wr_q);
              seg_addr  <= cur_addr;
              seg_len   <= pick_len;
              cur_addr  <= cur_addr + ADDR_W'(pick_len);
              rem       <= rem - REM_W'(pick_len);
            end else begin
              seg_valid <= 1'b0;
              seg_done  <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: descriptor frozen under backpressure
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_cmd) && $stable(seg_addr) && $stable(seg_len));

  // R2: 2-byte codes carry length 2 at an even address
  p_half_shape_r2: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_cmd[2:1] == 2'd0 |-> seg_len == SEG_W'(2) && !seg_addr[0]);

  // R3: 4-byte codes carry length 4 at a 4-aligned address
  p_word_shape_r3: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_cmd[2:1] == 2'd1 |-> seg_len == SEG_W'(4) && seg_addr[1:0] == 2'd0);

  // R4: bursts are 8-aligned, nonzero multiples of 8, within the cap
  p_burst_shape_r4: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_cmd[2] |-> seg_addr[2:0] == 3'd0 && seg_len[2:0] == 3'd0
                              && seg_len != '0 && seg_len <= SEG_W'(BURST_MAX));

  // R5: only six command codes exist
  p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> seg_cmd <= 3'd5);

  // R9: done is a single-cycle pulse with no descriptor alongside
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    seg_done |-> !seg_valid ##1 !seg_done);

  // R7: a rejection leaves the block idle with nothing presented
  p_err_idle_r7: assert property (@(posedge clk) disable iff (rst)
    seg_err |-> req_ready && !seg_valid);

  // R11: no descriptor appears while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !seg_valid);

endmodule

// File: tb/tb_xfer_segmenter.sv
module tb_xfer_segmenter;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int BMAX   = 240;
  localparam int SEG_W  = $clog2(BMAX + 1);
  localparam int NV     = 12;

  localparam logic [31:0] V_ADDR [NV] = '{32'h60030002, 32'h1000, 32'h1000, 32'h1004,
                                          32'h1006, 32'h0, 32'h4, 32'h2,
                                          32'h8, 32'h0, 32'h10, 32'h6};
  localparam int V_LEN [NV]  = '{260, 8, 4, 6, 2, 480, 250, 6, 14, 7, 0, 20};
  localparam bit V_WR  [NV]  = '{0, 1, 0, 1, 0, 0, 1, 0, 1, 1, 0, 1};
  localparam int V_NSEG [NV] = '{6, 1, 1, 2, 1, 2, 4, 2, 3, 1, 0, 3};
  localparam int GOLD_LEN [6] = '{2, 4, 240, 8, 4, 2};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_write = 1'b0;
  logic              seg_valid;
  logic              seg_ready = 1'b0;
  logic [2:0]        seg_cmd;
  logic [ADDR_W-1:0] seg_addr;
  logic [SEG_W-1:0]  seg_len;
  logic              seg_done;
  logic              seg_err;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  xfer_segmenter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_MAX(BMAX)) dut (
    .clk, .rst, .req_valid, .req_ready, .req_addr, .req_len, .req_write,
    .seg_valid, .seg_ready, .seg_cmd, .seg_addr, .seg_len, .seg_done, .seg_err
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void ref_pick(input logic [31:0] a, input int rem, input bit w,
                                   output int cmd, output int len);
    int al;
    al = int'(a[2:0]);
    if (al == 2 || al == 6 || rem == 2) begin
      cmd = 0; len = 2;
    end else if (al == 4 || rem <= 6) begin
      cmd = 2; len = 4;
    end else begin
      len = rem & ~7;
      if (len > BMAX) len = BMAX;
      cmd = 4;
    end
    if (w) cmd = cmd + 1;
  endfunction

  task automatic run_req(input logic [31:0] a, input int len, input bit w,
                         input bit bp, input bit poke, input int nseg, input bit gold);
    logic [31:0] m_addr;
    int m_rem, e_cmd, e_len, got, cyc;
    bit prev_hold, fin;
    logic [2:0] p_cmd;
    logic [ADDR_W-1:0] p_addr;
    logic [SEG_W-1:0] p_len;
    m_addr = a;
    m_rem = len + ((w && (len % 2 == 1)) ? 1 : 0);
    got = 0; cyc = 0; prev_hold = 0; fin = 0;
    p_cmd = '0; p_addr = '0; p_len = '0;
    req_addr = a; req_len = LEN_W'(len); req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      seg_ready = bp ? cyc[0] : 1'b1;
      if (poke) begin
        req_valid = !seg_done;
        req_addr = 32'h40; req_len = 16'd2; req_write = 1'b0;
        if (!seg_done) check(req_ready == 1'b0, "R11", "ready while busy", req_ready, 0);
      end
      if (prev_hold)
        check(seg_valid && seg_cmd == p_cmd && seg_addr == p_addr && seg_len == p_len,
              "R10", "held descriptor", seg_addr, p_addr);
      if (seg_done) begin
        check(seg_valid == 1'b0, "R9", "valid with done", seg_valid, 0);
        check(m_rem == 0 && got == nseg, "R9", "segments at done", got, nseg);
        fin = 1;
      end else if (seg_valid && seg_ready) begin
        ref_pick(m_addr, m_rem, w, e_cmd, e_len);
        check(seg_addr == m_addr, "R6", "segment address", seg_addr, m_addr);
        check(int'(seg_len) == e_len, e_cmd / 2 == 0 ? "R2" : (e_cmd / 2 == 1 ? "R3" : "R4"),
              "segment length", seg_len, e_len);
        check(int'(seg_cmd) == e_cmd, "R5", "command code", seg_cmd, e_cmd);
        if (gold && got < 6)
          check(int'(seg_len) == GOLD_LEN[got], "R6", "example length", seg_len, GOLD_LEN[got]);
        m_addr = m_addr + 32'(e_len);
        m_rem = m_rem - e_len;
        got++;
      end
      prev_hold = seg_valid && !seg_ready && !seg_done;
      p_cmd = seg_cmd; p_addr = seg_addr; p_len = seg_len;
      if (cyc > 2000) begin
        check(1'b0, "R9", "done never seen", got, nseg);
        fin = 1;
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    check(seg_done == 1'b0, "R9", "done width", seg_done, 0);
    check(req_ready && !seg_valid, "R11", "idle after done", seg_valid, 0);
    if (poke) begin
      @(negedge clk);
      check(!seg_valid && req_ready, "R11", "busy offer ignored", seg_valid, 0);
    end
  endtask

  task automatic bad_req(input logic [31:0] a, input int len, input bit w);
    req_addr = a; req_len = LEN_W'(len); req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(seg_err == 1'b1, "R7", "error pulse", seg_err, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!seg_valid && !seg_err && req_ready, "R7", "no segments after error", seg_valid, 0);
    end
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !seg_valid && !seg_done && !seg_err, "R1", "reset state",
          {req_ready, seg_valid, seg_done, seg_err}, 4'b1000);

    for (int i = 0; i < NV; i++)
      run_req(V_ADDR[i], V_LEN[i], V_WR[i], i % 2 == 1, i == 5, V_NSEG[i], i == 0);

    // R8: odd write of 7 bytes becomes one 8-byte burst
    run_req(32'h100, 7, 1'b1, 1'b1, 1'b0, 1, 1'b0);
    // R7: rejections
    bad_req(32'h1001, 8, 1'b0);
    bad_req(32'h2003, 4, 1'b1);
    bad_req(32'h2000, 5, 1'b0);
    // R3: 6 bytes at an aligned address -> 4 then 2
    run_req(32'h3000, 6, 1'b0, 1'b0, 1'b0, 2, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule